// File: doc/BRIEF.md
# Machine Check Exception Entry Unit

This block decides what a 32-bit processor core does when the bus reports a failed access. It samples a single-cycle error strobe together with the access type (instruction fetch or load/store), the current machine state word, the effective address of the faulting instruction, the instruction encoding and the data effective address. When machine checks are enabled, it builds the register images the handler needs: the two save/restore words, the new machine state word, the data fault status word and the data address. It also issues a one-cycle fetch redirect to the machine check vector.

When machine checks are disabled, the block stops the core. It either parks it in a debug state, when debug mode is enabled, or in a halted checkstop state that also requests a system reset. Both stopped states persist until a synchronous reset, and further error strobes are ignored while in them. Bit numbers in the requirements use big-endian notation (bit 0 is the most significant, so big-endian bit k is port bit 31-k). The machine state fields used are: IP at bit 25 (port bit 6), ME at bit 19 (port bit 12), ILE at bit 15 (port bit 16), LE at bit 31 (port bit 0) and RI at bit 30 (port bit 1).

Top module: `mchk_entry`

## Requirements
- R1: After synchronous reset every output is zero.
- R2: An error strobe sampled while running with ME=1 gives, in the following cycle only, `redirect_vld_o`=1. `redirect_addr_o` is 0xFFF00200 when IP=1 and 0x00000200 when IP=0.
- R3: An error strobe with ME=0 and `debug_en_i`=1 raises `debug_o`. The saved register outputs do not change and no redirect is issued.
- R4: An error strobe with ME=0 and `debug_en_i`=0 raises `checkstop_o` and `rst_req_o`. The saved register outputs do not change and no redirect is issued.
- R5: The debug and checkstop states hold until reset. Error strobes received in either state change no output.
- R6: On a taken machine check, `srr0_o` receives `inst_ea_i`.
- R7: On a taken machine check, `srr1_o` bit 1 is 1 for a fetch error and 0 for a load/store error. Bits 0 and 2–15 are 0, and bits 16–31 copy the machine state bits 16–31 (so bit 30 carries RI).
- R8: On a taken machine check, `msr_o` keeps IP and sets LE to the old ILE. All other bits are 0, so ME is cleared.
- R9: For a load/store error whose instruction has primary opcode 31 (instruction bits 0–5 = 31, X-form), DSISR bits 15–16 take instruction bits 29–30, bit 17 takes bit 25, bits 18–21 take bits 21–24 and bits 22–31 take bits 6–15. All other DSISR bits are 0.
- R10: For a load/store error with any other opcode (D-form), DSISR bits 15–16 are 0, bit 17 takes instruction bit 5, bits 18–21 take bits 1–4 and bits 22–31 take bits 6–15. All other DSISR bits are 0.
- R11: A load/store error loads `dar_o` with `data_ea_i`. A fetch error leaves `dsisr_o` and `dar_o` at their previous values.
- R12: Without an error strobe, no output changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| err_i | input | 1 | Single-cycle bus error strobe |
| err_is_fetch_i | input | 1 | 1: failed access was an instruction fetch; 0: load/store |
| debug_en_i | input | 1 | Debug mode enabled |
| msr_i | input | 32 | Current machine state word |
| inst_ea_i | input | 32 | Effective address of the faulting instruction |
| inst_word_i | input | 32 | Encoding of the faulting instruction |
| data_ea_i | input | 32 | Effective address of the failing data access |
| srr0_o | output | 32 | Saved instruction address |
| srr1_o | output | 32 | Saved status image |
| msr_o | output | 32 | Machine state word for the handler |
| dsisr_o | output | 32 | Data fault status image |
| dar_o | output | 32 | Data address register |
| redirect_vld_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_addr_o | output | 32 | Fetch redirect address |
| checkstop_o | output | 1 | Core is in checkstop |
| debug_o | output | 1 | Core is in debug state |
| rst_req_o | output | 1 | Reset request to the system interface |

## Verification
Every stored value reaches a port one cycle after the error strobe, so a wrong image or a wrong state shows at the first sample after the strobe. A wrong mode choice shows as a missing or extra redirect pulse, or as the wrong halt flag. A state that fails to hold is caught by the next strobe sent into a halted core: it either redirects or overwrites the saved words. A wrong bit in the DSISR or SRR1 images shows only for instruction words or status words that have that bit set, so the patterns use dense and sparse words in both instruction forms.

// File: rtl/mchk_pkg.sv
package mchk_pkg;

    localparam int unsigned XLEN = 32;

    // big-endian field numbers, converted to port bit indices
    localparam int unsigned MSR_IP  = XLEN - 1 - 25;
    localparam int unsigned MSR_ME  = XLEN - 1 - 19;
    localparam int unsigned MSR_ILE = XLEN - 1 - 15;
    localparam int unsigned MSR_LE  = XLEN - 1 - 31;
    localparam int unsigned SRR1_IFETCH = XLEN - 1 - 1;
    localparam int unsigned LOW_HALF = XLEN / 2;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_DEBUG    = 2'd1,
        ST_CHKSTOP  = 2'd2
    } mchk_state_e;

    typedef struct packed {
        mchk_state_e     state;
        logic [XLEN-1:0] srr0;
        logic [XLEN-1:0] srr1;
        logic [XLEN-1:0] msr;
        logic [XLEN-1:0] dsisr;
        logic [XLEN-1:0] dar;
        logic [XLEN-1:0] redir_addr;
        logic            redir_vld;
    } mchk_regs_t;

endpackage

// File: rtl/mchk_dsisr_fmt.sv
module mchk_dsisr_fmt
    import mchk_pkg::*;
#(
    parameter int unsigned XFORM_OPCODE = 31,
    parameter int unsigned OPC_W        = 6
) (
    input  logic [XLEN-1:0] inst_i,
    output logic            is_xform_o,
    output logic [XLEN-1:0] dsisr_o
);
    localparam int unsigned BE_FIELD_LO = 22;
    localparam int unsigned FIELD_N     = 10;
    localparam int unsigned REG_N       = 4;

    // primary opcode occupies the top OPC_W bits
    assign is_xform_o = (inst_i[XLEN-1 -: OPC_W] == OPC_W'(XFORM_OPCODE));

    logic [XLEN-1:0] img;

    always_comb begin
        img = '0;
        if (is_xform_o) begin
            img[XLEN-1-15] = inst_i[XLEN-1-29];
            img[XLEN-1-16] = inst_i[XLEN-1-30];
            img[XLEN-1-17] = inst_i[XLEN-1-25];
            for (int i = 0; i < int'(REG_N); i++)
                img[XLEN-1-(18+i)] = inst_i[XLEN-1-(21+i)];
        end else begin
            img[XLEN-1-17] = inst_i[XLEN-1-5];
            for (int i = 0; i < int'(REG_N); i++)
                img[XLEN-1-(18+i)] = inst_i[XLEN-1-(1+i)];
        end
        for (int i = 0; i < int'(FIELD_N); i++)
            img[XLEN-1-(BE_FIELD_LO+i)] = inst_i[XLEN-1-(6+i)];
    end

    assign dsisr_o = img;

    logic inst_bits_unused;
    assign inst_bits_unused = ^{inst_i[0], inst_i[5:3], inst_i[15:11]};

endmodule

// File: rtl/mchk_status_img.sv
module mchk_status_img
    import mchk_pkg::*;
#(
    parameter logic [XLEN-1:0] VEC_OFFSET = 32'h0000_0200,
    parameter logic [XLEN-1:0] HIGH_BASE  = 32'hFFF0_0000
) (
    input  logic [XLEN-1:0] msr_i,
    input  logic            is_fetch_i,
    output logic [XLEN-1:0] srr1_o,
    output logic [XLEN-1:0] msr_o,
    output logic [XLEN-1:0] vector_o
);
    always_comb begin
        srr1_o = '0;
        srr1_o[LOW_HALF-1:0] = msr_i[LOW_HALF-1:0];
        srr1_o[SRR1_IFETCH]  = is_fetch_i;
    end

    always_comb begin
        msr_o = '0;
        msr_o[MSR_IP] = msr_i[MSR_IP];
        msr_o[MSR_LE] = msr_i[MSR_ILE];
    end

    assign vector_o = msr_i[MSR_IP] ? (HIGH_BASE | VEC_OFFSET) : VEC_OFFSET;

    logic msr_hi_unused;
    assign msr_hi_unused = ^msr_i[XLEN-1:MSR_ILE+1];

endmodule

// File: rtl/mchk_entry.sv
module mchk_entry
    import mchk_pkg::*;
#(
    parameter logic [31:0] VEC_OFFSET   = 32'h0000_0200,
    parameter logic [31:0] HIGH_BASE    = 32'hFFF0_0000,
    parameter int unsigned XFORM_OPCODE = 31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        err_i,
    input  logic        err_is_fetch_i,
    input  logic        debug_en_i,
    input  logic [31:0] msr_i,
    input  logic [31:0] inst_ea_i,
    input  logic [31:0] inst_word_i,
    input  logic [31:0] data_ea_i,
    output logic [31:0] srr0_o,
    output logic [31:0] srr1_o,
    output logic [31:0] msr_o,
    output logic [31:0] dsisr_o,
    output logic [31:0] dar_o,
    output logic        redirect_vld_o,
    output logic [31:0] redirect_addr_o,
    output logic        checkstop_o,
    output logic        debug_o,
    output logic        rst_req_o
);
    mchk_regs_t r_q, r_d;

    logic [XLEN-1:0] srr1_img, msr_img, vec_addr, dsisr_img;
    logic            xform;

    mchk_status_img #(
        .VEC_OFFSET (VEC_OFFSET),
        .HIGH_BASE  (HIGH_BASE)
    ) u_status (
        .msr_i      (msr_i),
        .is_fetch_i (err_is_fetch_i),
        .srr1_o     (srr1_img),
        .msr_o      (msr_img),
        .vector_o   (vec_addr)
    );

    mchk_dsisr_fmt #(
        .XFORM_OPCODE (XFORM_OPCODE)
    ) u_dsisr (
        .inst_i     (inst_word_i),
        .is_xform_o (xform),
        .dsisr_o    (dsisr_img)
    );

    logic xform_unused;
    assign xform_unused = xform;

    always_comb begin
        r_d           = r_q;
        r_d.redir_vld = 1'b0;
        if (r_q.state == ST_RUN && err_i) begin
            if (msr_i[MSR_ME]) begin
                r_d.srr0       = inst_ea_i;
                r_d.srr1       = srr1_img;
                r_d.msr        = msr_img;
                r_d.redir_vld  = 1'b1;
                r_d.redir_addr = vec_addr;
                if (!err_is_fetch_i) begin
                    r_d.dsisr = dsisr_img;
                    r_d.dar   = data_ea_i;
                end
            end else if (debug_en_i) begin
                r_d.state = ST_DEBUG;
            end else begin
                r_d.state = ST_CHKSTOP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_RUN, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign srr0_o          = r_q.srr0;
    assign srr1_o          = r_q.srr1;
    assign msr_o           = r_q.msr;
    assign dsisr_o         = r_q.dsisr;
    assign dar_o           = r_q.dar;
    assign redirect_vld_o  = r_q.redir_vld;
    assign redirect_addr_o = r_q.redir_addr;
    assign checkstop_o     = (r_q.state == ST_CHKSTOP);
    assign debug_o         = (r_q.state == ST_DEBUG);
    assign rst_req_o       = (r_q.state == ST_CHKSTOP);

endmodule

// File: rtl/mchk_entry_chk.sv
module mchk_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic        err_i,
    input logic        err_is_fetch_i,
    input logic        debug_en_i,
    input logic [31:0] msr_i,
    input logic [31:0] srr0_o,
    input logic [31:0] dsisr_o,
    input logic [31:0] dar_o,
    input logic [31:0] msr_o,
    input logic        redirect_vld_o,
    input logic        checkstop_o,
    input logic        debug_o,
    input logic        rst_req_o
);
    // R2: redirect only follows an enabled machine check
    assert_redirect_cause_R2: assert property (@(posedge clk) disable iff (rst)
        redirect_vld_o |-> ($past(err_i) && $past(msr_i[12])));

    // R2: redirect lasts one cycle when no new strobe arrives
    assert_redirect_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (redirect_vld_o && !err_i) |=> !redirect_vld_o);

    // R3: debug entry only from ME=0 with debug mode on
    assert_debug_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(debug_o) |-> ($past(err_i) && !$past(msr_i[12]) && $past(debug_en_i)));

    // R4: checkstop entry only from ME=0 with debug mode off, with reset request
    assert_chkstop_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(checkstop_o) |-> ($past(err_i) && !$past(msr_i[12]) && !$past(debug_en_i) && rst_req_o));

    // R5: halted states hold and freeze the saved words
    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (checkstop_o || debug_o) |=> ($stable(checkstop_o) && $stable(debug_o) && $stable(srr0_o) && !redirect_vld_o));

    // R5: never two modes at once
    assert_mode_excl_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({checkstop_o, debug_o, redirect_vld_o}));

    // R8: handler MSR always has ME cleared
    assert_me_clear_R8: assert property (@(posedge clk) disable iff (rst)
        redirect_vld_o |-> !msr_o[12]);

    // R11: fetch errors keep the data fault words
    assert_fetch_keep_R11: assert property (@(posedge clk) disable iff (rst)
        (redirect_vld_o && $past(err_is_fetch_i)) |-> ($stable(dsisr_o) && $stable(dar_o)));

endmodule

bind mchk_entry mchk_entry_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .err_i          (err_i),
    .err_is_fetch_i (err_is_fetch_i),
    .debug_en_i     (debug_en_i),
    .msr_i          (msr_i),
    .srr0_o         (srr0_o),
    .dsisr_o        (dsisr_o),
    .dar_o          (dar_o),
    .msr_o          (msr_o),
    .redirect_vld_o (redirect_vld_o),
    .checkstop_o    (checkstop_o),
    .debug_o        (debug_o),
    .rst_req_o      (rst_req_o)
);

// File: tb/mchk_entry_bench.sv
module mchk_entry_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_i = 1'b0, err_is_fetch_i = 1'b0, debug_en_i = 1'b0;
    logic [31:0] msr_i = '0, inst_ea_i = '0, inst_word_i = '0, data_ea_i = '0;
    logic [31:0] srr0_o, srr1_o, msr_o, dsisr_o, dar_o, redirect_addr_o;
    logic        redirect_vld_o, checkstop_o, debug_o, rst_req_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // expected state tracked by the bench
    logic [31:0] e_srr0 = '0, e_srr1 = '0, e_msr = '0, e_dsisr = '0, e_dar = '0, e_vec = '0;

    always #4 clk = ~clk;

    mchk_entry u_mchk_entry (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] x_dsisr(input logic [31:0] w);
        logic [31:0] r = '0;
        if (w[31:26] == 6'd31) begin
            r[31-15] = w[31-29]; r[31-16] = w[31-30]; r[31-17] = w[31-25];
            for (int i = 0; i < 4; i++) r[31-(18+i)] = w[31-(21+i)];
        end else begin
            r[31-17] = w[31-5];
            for (int i = 0; i < 4; i++) r[31-(18+i)] = w[31-(1+i)];
        end
        for (int i = 0; i < 10; i++) r[31-(22+i)] = w[31-(6+i)];
        return r;
    endfunction

    function automatic logic [31:0] x_srr1(input logic [31:0] m, input logic f);
        logic [31:0] r = '0;
        r[31-1] = f;
        for (int k = 16; k < 32; k++) r[31-k] = m[31-k];
        return r;
    endfunction

    function automatic logic [31:0] x_msr(input logic [31:0] m);
        logic [31:0] r = '0;
        r[31-25] = m[31-25];
        r[31-31] = m[31-15];
        return r;
    endfunction

    task automatic check_saved(input string req);
        check({req, " srr0"}, srr0_o, e_srr0);
        check({req, " srr1"}, srr1_o, e_srr1);
        check({req, " msr"}, msr_o, e_msr);
        check({req, " dsisr"}, dsisr_o, e_dsisr);
        check({req, " dar"}, dar_o, e_dar);
        check({req, " vec"}, redirect_addr_o, e_vec);
    endtask

    task automatic pulse(input logic [31:0] m, input logic f, input logic dbg,
                         input logic [31:0] iea, input logic [31:0] iw, input logic [31:0] dea);
        @(negedge clk);
        msr_i = m; err_is_fetch_i = f; debug_en_i = dbg;
        inst_ea_i = iea; inst_word_i = iw; data_ea_i = dea; err_i = 1'b1;
        @(negedge clk);
        err_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        e_srr0 = '0; e_srr1 = '0; e_msr = '0; e_dsisr = '0; e_dar = '0; e_vec = '0;
    endtask

    task automatic t_reset();
        do_reset();
        check_saved("R1");
        check("R1 flags", {29'b0, redirect_vld_o, checkstop_o, debug_o}, 32'h0);
        check("R1 rstreq", {31'b0, rst_req_o}, 32'h0);
    endtask

    task automatic t_take(input string req, input logic [31:0] m, input logic f,
                          input logic [31:0] iea, input logic [31:0] iw, input logic [31:0] dea);
        pulse(m, f, 1'b0, iea, iw, dea);
        e_srr0 = iea; e_srr1 = x_srr1(m, f); e_msr = x_msr(m);
        e_vec = m[31-25] ? 32'hFFF0_0200 : 32'h0000_0200;
        if (!f) begin e_dsisr = x_dsisr(iw); e_dar = dea; end
        check({req, " R2 strobe"}, {31'b0, redirect_vld_o}, 32'h1);
        check_saved({req, " R6 R7 R8 R9 R10 R11"});
        @(negedge clk);
        check({req, " R2 pulse end"}, {31'b0, redirect_vld_o}, 32'h0);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            msr_i = 32'hFFFF_FFFF ^ i; inst_ea_i = 32'h1234_0000 + i;
            inst_word_i = 32'h7FFF_FFFF; data_ea_i = 32'hDEAD_0000 + i; err_is_fetch_i = i[0];
        end
        @(negedge clk);
        check_saved("R12 idle");
        check("R12 no redirect", {31'b0, redirect_vld_o}, 32'h0);
    endtask

    task automatic t_halt(input logic dbg);
        string rq = dbg ? "R3" : "R4";
        pulse(32'hFFFF_EFFF, 1'b0, dbg, 32'hAAAA_0000, 32'h7C00_0000, 32'hBBBB_0000);
        check({rq, " debug"}, {31'b0, debug_o}, {31'b0, dbg});
        check({rq, " checkstop"}, {31'b0, checkstop_o}, {31'b0, !dbg});
        check({rq, " rst_req"}, {31'b0, rst_req_o}, {31'b0, !dbg});
        check({rq, " no redirect"}, {31'b0, redirect_vld_o}, 32'h0);
        check_saved({rq, " unchanged"});
        // R5: a strobe with ME=1 while halted is ignored
        pulse(32'hFFFF_FFFF, 1'b0, dbg, 32'h5555_0000, 32'h8123_4567, 32'h6666_0000);
        check("R5 no redirect", {31'b0, redirect_vld_o}, 32'h0);
        check_saved("R5 ignored");
        repeat (3) @(negedge clk);
        check("R5 held", {30'b0, checkstop_o, debug_o}, {30'b0, !dbg, dbg});
        do_reset();
        check("R1 after halt", {29'b0, rst_req_o, checkstop_o, debug_o}, 32'h0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_idle();
        t_take("Xform IP1", 32'hFFFF_FFFF, 1'b0, 32'h0000_1004, 32'h7D2A_3C56, 32'h8000_0010);
        t_take("Dform IP0", 32'h0000_1000, 1'b0, 32'h0000_2008, 32'h8123_4567, 32'h4000_0020);
        t_take("fetch", 32'h0001_9043, 1'b1, 32'h0000_300C, 32'h7C00_0000, 32'h1111_1111);
        t_take("Dform dense", 32'h0000_5A5E, 1'b0, 32'hFFFF_FFFC, 32'hBFFF_FFFF, 32'hFFFF_FFF0);
        t_take("Xform sparse", 32'h0000_1002, 1'b0, 32'h0000_0040, 32'h7C00_0002, 32'h0000_0004);
        t_idle();
        t_halt(1'b1);
        t_take("after debug", 32'h0000_1040, 1'b1, 32'h0000_0100, 32'h0, 32'h0);
        t_halt(1'b0);
        t_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule